// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a 32-bit RISC core and chooses the address of the next instruction on every clock. The core presents the instruction word fetched at the current address together with the two register operands that a conditional branch compares and the register value that an indirect jump uses. On the next rising edge the block loads one of five candidates into the counter:
- the sequential address;
- a taken PC-relative branch target;
- a region-preserving absolute jump target;
- a register target;
- a call target.

A call also produces its return address and asks for it to be written to register 31 during the same cycle.

A stall input freezes the counter and suppresses the return-address write. Register targets that are not word aligned are flagged and rounded down, so the counter never leaves word alignment.

Top module: `pc_sequencer`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released until the first clock edge, pc is 0x00400000 and linkWrite is 0.
- R2: An instruction that is neither a branch nor a jump advances pc by 4 at the next edge. Examples are major opcode (bits 31:26) 0 with funct (bits 5:0) other than 0x08, and opcode 0x23.
- R3: Opcode 4 (branch-if-equal) with opA equal to opB loads pc + 4 + (sign-extended bits 15:0 shifted left by 2). With opA not equal to opB it loads pc + 4.
- R4: Opcode 5 (branch-if-different) takes the same target when opA differs from opB. It falls through to pc + 4 when they are equal.
- R5: A branch offset with bit 15 set moves pc backwards. For example, an offset of 0xFFFE gives pc + 4 - 8.
- R6: Opcode 2 (jump) loads {pc[31:28], bits 25:0, 2'b00}, keeping the top four bits of the current pc. For example, an index of 2500 from region 0 gives 10000.
- R7: Opcode 3 (call) jumps like R6. During that cycle it drives linkWrite = 1, linkDest = 31 and linkAddr = pc + 4.
- R8: Opcode 0 with funct 0x08 (register jump) loads pc from jrValue, and jrMisalign stays 0 when jrValue[1:0] is 0.
- R9: A register jump with jrValue[1:0] not zero drives jrMisalign = 1 in that cycle and loads jrValue with bits 1:0 cleared.
- R10: While stall is 1, pc keeps its value across the edge and linkWrite is 0, whatever the instruction.
- R11: pc[1:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold the counter and suppress the link write |
| instr | input | 32 | Instruction word at the current pc |
| opA | input | 32 | First compared register operand |
| opB | input | 32 | Second compared register operand |
| jrValue | input | 32 | Register value used by a register jump |
| pc | output | 32 | Current program counter |
| linkAddr | output | 32 | Return address, pc + 4 |
| linkWrite | output | 1 | Request to write linkAddr to register linkDest |
| linkDest | output | 5 | Register index of the link write, always 31 |
| jrMisalign | output | 1 | Register jump target had nonzero low bits |

## Verification
Each branch opcode is driven once with equal operands and once with different operands. This separates the equality sense of the two opcodes and shows that a not-taken branch still falls through by 4. A forward offset and a negative offset are applied so that a zero-extension mistake is caught. Jumps are issued from region 0 and again after a register jump into region 8, which shows that the top four bits come from the current counter rather than from the instruction. Register jumps with aligned and unaligned values, and stalled calls and jumps, check the alignment flag and the suppression of the link write.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_W   = 5;

  localparam logic [OPC_W-1:0] OPC_REGOP = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_CALL  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNE  = 6'h05;
  localparam logic [OPC_W-1:0] FN_REGJMP = 6'h08;

  localparam logic [REG_W-1:0] LINK_REG  = 5'd31;

  typedef struct packed {
    logic takeBranch;
    logic doJump;
    logic doRegJump;
  } pcStrobe_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [1:0]         jrLow,
  output pcStrobe_t          strb,
  output logic               linkWrite,
  output logic [REG_W-1:0]   linkDest,
  output logic               jrMisalign
);

  logic [OPC_W-1:0] opcode;
  logic [OPC_W-1:0] funct;
  logic             opsEqual;
  logic             isCall;

  assign opcode   = instr[INSTR_W-1 -: OPC_W];
  assign funct    = instr[OPC_W-1:0];
  assign opsEqual = (opA == opB);

  always_comb begin
    strb   = '0;
    isCall = 1'b0;
    unique case (opcode)
      OPC_REGOP: strb.doRegJump  = (funct == FN_REGJMP);
      OPC_JUMP:  strb.doJump     = 1'b1;
      OPC_CALL: begin
        strb.doJump = 1'b1;
        isCall      = 1'b1;
      end
      OPC_BREQ:  strb.takeBranch = opsEqual;
      OPC_BRNE:  strb.takeBranch = !opsEqual;
      default: ;
    endcase
  end

  assign linkWrite  = isCall && !stall;
  assign linkDest   = LINK_REG;
  assign jrMisalign = strb.doRegJump && (jrLow != 2'b00);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeBranch, strb.doJump, strb.doRegJump})); // R2

  AST_MISALIGN_NEEDS_REGJMP: assert property (@(posedge clk) disable iff (!rstN)
    jrMisalign |-> (opcode == OPC_REGOP && funct == FN_REGJMP)); // R9

  AST_LINK_ON_CALL: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> (opcode == OPC_CALL && linkDest == LINK_REG)); // R7

endmodule

// File: rtl/pcseq_path.sv
module pcseq_path
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  pcStrobe_t          strb,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  jrValue,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  linkAddr
);

  localparam int                OFS_W    = 16;
  localparam int                IDX_W    = 26;
  localparam int                REGION_W = ADDR_W - IDX_W - 2;
  localparam int                EXT_W    = ADDR_W - OFS_W - 2;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] branchDisp;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] regTarget;

  assign pcPlus4    = pcQ + STEP;
  assign branchDisp = {{EXT_W{instr[OFS_W-1]}}, instr[OFS_W-1:0], 2'b00};
  assign jumpTarget = {pcQ[ADDR_W-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
  assign regTarget  = {jrValue[ADDR_W-1:2], 2'b00};

  always_comb begin
    if (strb.doRegJump)       pcNext = regTarget;
    else if (strb.doJump)     pcNext = jumpTarget;
    else if (strb.takeBranch) pcNext = pcPlus4 + branchDisp;
    else                      pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pcQ <= RESET_PC;
    else if (!stall) pcQ <= pcNext;
  end

  assign pc       = pcQ;
  assign linkAddr = pcPlus4;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    pc[1:0] == 2'b00); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (pc == $past(pc))); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && strb == '0) |=> (pc == $past(pc) + STEP)); // R2

  AST_REGJMP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && strb.doRegJump) |=> (pc == {$past(jrValue[ADDR_W-1:2]), 2'b00})); // R8

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && strb.doJump) |=>
      (pc[ADDR_W-1 -: REGION_W] == $past(pc[ADDR_W-1 -: REGION_W]))); // R6

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [ADDR_W-1:0]  jrValue,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  linkAddr,
  output logic               linkWrite,
  output logic [REG_W-1:0]   linkDest,
  output logic               jrMisalign
);

  pcStrobe_t strb;

  pcseq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stall      (stall),
    .instr      (instr),
    .opA        (opA),
    .opB        (opB),
    .jrLow      (jrValue[1:0]),
    .strb       (strb),
    .linkWrite  (linkWrite),
    .linkDest   (linkDest),
    .jrMisalign (jrMisalign)
  );

  pcseq_path #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stall    (stall),
    .strb     (strb),
    .instr    (instr),
    .jrValue  (jrValue),
    .pc       (pc),
    .linkAddr (linkAddr)
  );

endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stall;
  logic [31:0] instr, opA, opB, jrValue;
  logic [31:0] pc, linkAddr;
  logic        linkWrite, jrMisalign;
  logic [4:0]  linkDest;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expPc;
  logic        sLw, sMis;
  logic [4:0]  sLd;
  logic [31:0] sLa;

  always #4 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rstN(rstN), .stall(stall), .instr(instr), .opA(opA), .opB(opB),
    .jrValue(jrValue), .pc(pc), .linkAddr(linkAddr), .linkWrite(linkWrite),
    .linkDest(linkDest), .jrMisalign(jrMisalign)
  );

  function automatic logic [31:0] mkI(input logic [5:0] op, input logic [15:0] ofs);
    return {op, 5'd8, 5'd9, ofs};
  endfunction
  function automatic logic [31:0] mkJ(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] mkR(input logic [5:0] fn);
    return {6'h00, 5'd9, 5'd0, 5'd0, 5'd0, fn};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // drive at negedge, capture combinational outputs, cross one rising edge
  task automatic step(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] j, input logic st);
    instr = i; opA = a; opB = b; jrValue = j; stall = st;
    #1;
    sLw = linkWrite; sLd = linkDest; sLa = linkAddr; sMis = jrMisalign;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rstN = 1'b0; stall = 1'b0; instr = 32'h0; opA = 0; opB = 0; jrValue = 0;
    repeat (3) @(negedge clk);
    chk("R1 pc during reset", pc, 32'h0040_0000);
    rstN = 1'b1;
    #1;
    chk("R1 pc after release", pc, 32'h0040_0000);
    chk("R1 linkWrite after release", {31'b0, linkWrite}, 32'h0);
    expPc = 32'h0040_0000;
  endtask

  task automatic t_sequential;
    step(32'h0109_5021, 0, 0, 0, 1'b0);
    expPc += 4;
    chk("R2 register op advances", pc, expPc);
    step(mkI(6'h23, 16'h0018), 1, 2, 0, 1'b0);
    expPc += 4;
    chk("R2 load op advances", pc, expPc);
    chk("R11 pc aligned", {30'b0, pc[1:0]}, 32'h0);
  endtask

  task automatic t_branch_eq;
    step(mkI(6'h04, 16'h0003), 32'd5, 32'd5, 0, 1'b0);
    expPc = expPc + 4 + 12;
    chk("R3 equal branch taken", pc, expPc);
    step(mkI(6'h04, 16'h0003), 32'd5, 32'd6, 0, 1'b0);
    expPc = expPc + 4;
    chk("R3 equal branch not taken", pc, expPc);
  endtask

  task automatic t_branch_ne;
    step(mkI(6'h05, 16'h0010), 32'hA, 32'hB, 0, 1'b0);
    expPc = expPc + 4 + 64;
    chk("R4 differ branch taken", pc, expPc);
    step(mkI(6'h05, 16'h0010), 32'hC, 32'hC, 0, 1'b0);
    expPc = expPc + 4;
    chk("R4 differ branch not taken", pc, expPc);
  endtask

  task automatic t_branch_back;
    step(mkI(6'h04, 16'hFFFE), 32'h7, 32'h7, 0, 1'b0);
    expPc = expPc + 4 - 8;
    chk("R5 backward branch", pc, expPc);
  endtask

  task automatic t_jump;
    step(mkJ(6'h02, 26'd2500), 0, 0, 0, 1'b0);
    expPc = 32'd10000;
    chk("R6 jump index 2500 region 0", pc, expPc);
  endtask

  task automatic t_regjump;
    step(mkR(6'h08), 0, 0, 32'h8000_1230, 1'b0);
    chk("R8 aligned jr no flag", {31'b0, sMis}, 32'h0);
    expPc = 32'h8000_1230;
    chk("R8 jr loads pc", pc, expPc);
    step(mkJ(6'h02, 26'h10), 0, 0, 0, 1'b0);
    expPc = 32'h8000_0040;
    chk("R6 jump keeps region 8", pc, expPc);
  endtask

  task automatic t_misalign;
    step(mkR(6'h08), 0, 0, 32'h0040_2003, 1'b0);
    chk("R9 misalign flag", {31'b0, sMis}, 32'h1);
    expPc = 32'h0040_2000;
    chk("R9 rounded target", pc, expPc);
    chk("R11 pc aligned after jr", {30'b0, pc[1:0]}, 32'h0);
  endtask

  task automatic t_call;
    logic [31:0] ret;
    ret = expPc + 4;
    step(mkJ(6'h03, 26'h0000_100), 0, 0, 0, 1'b0);
    chk("R7 link write", {31'b0, sLw}, 32'h1);
    chk("R7 link dest", {27'b0, sLd}, 32'd31);
    chk("R7 link addr", sLa, ret);
    expPc = {ret[31:28] & 4'h0 | expPc[31:28], 26'h0000_100, 2'b00};
    chk("R7 call target", pc, expPc);
  endtask

  task automatic t_stall;
    step(mkJ(6'h03, 26'h00_0200), 0, 0, 0, 1'b1);
    chk("R10 no link write on stall", {31'b0, sLw}, 32'h0);
    chk("R10 pc held on stalled call", pc, expPc);
    step(mkR(6'h08), 0, 0, 32'h1234_5678, 1'b1);
    chk("R10 pc held on stalled jr", pc, expPc);
    step(32'h0, 0, 0, 0, 1'b0);
    expPc += 4;
    chk("R2 advance after stall", pc, expPc);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_branch_eq();
    t_branch_ne();
    t_branch_back();
    t_jump();
    t_regjump();
    t_misalign();
    t_call();
    t_stall();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule